// File: doc/BRIEF.md
# LCD panel power sequencer

This block brings an LCD panel up and down in a fixed order, counting every wait in whole frames. A frame-tick strobe from the display timing generator is the only time base. Three enables leave the block: the logic supply, the display outputs (which gate pixel data and the timing signals) and the bias/drive supply. A 2-bit status shows how far the sequence has gone.

Software writes a control word that holds a display-on bit and a confirm bit. A delay word holds two 4-bit power-off waits, each programmed as the frame count minus one. The power-on waits are a build-time parameter in the same minus-one form. Power-up starts only when both control bits are 1. Clearing the display-on bit starts power-down. The display-on bit cannot be changed while a sequence is running. If that bit is already 0 when power-up finishes, power-down follows at once.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset all three enables are 0, the status is 00, the display-on and confirm readbacks are 0, the first off-delay readback is 0 and the second is 15.
- R2: With only the display-on bit set and the confirm bit 0, no sequence starts and the status stays 00.
- R3: Power-up runs in order. Logic enable rises with status 01. After ON_DLY_M1+1 frame ticks the display enable rises with status 10. After ON_DLY_M1+1 further ticks the bias enable rises with status 11. The status only ever moves by one step at a time.
- R4: With status 11, writing the display-on bit as 0 drops the bias enable and sets status 10 without waiting for a frame tick.
- R5: After the bias enable drops, the display enable drops with status 01 after (first off-delay field + 1) frame ticks.
- R6: After the display enable drops, the logic enable drops with status 00 after (second off-delay field + 1) frame ticks.
- R7: The sequence never advances in a cycle without a frame tick.
- R8: While the status is 01 or 10, writes to the display-on bit are ignored. Its readback keeps its value.
- R9: If the display-on bit is 0 when power-up reaches status 11, power-down starts in the next cycle. The status leaves 11 with no frame tick in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameTick | input | 1 | One-cycle frame strobe |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlOnIn | input | 1 | Display-on bit write value |
| ctrlConfIn | input | 1 | Confirm bit write value |
| dlyWr | input | 1 | Delay word write strobe |
| dlyAIn | input | DLY_W | First off-delay write value (bias off to display off) |
| dlyBIn | input | DLY_W | Second off-delay write value (display off to logic off) |
| logicEn | output | 1 | Logic supply enable |
| dispEn | output | 1 | Display data/timing output enable |
| biasEn | output | 1 | Bias/drive supply enable |
| pwrState | output | 2 | Power status: 00 off, 01, 10, 11 fully on |
| onBit | output | 1 | Display-on bit readback |
| confBit | output | 1 | Confirm bit readback |
| dlyA | output | DLY_W | First off-delay readback |
| dlyB | output | DLY_W | Second off-delay readback |

## Verification
Two events can land on the same clock edge: the decision to start power-up, and a write that clears the display-on bit. The bench provokes this with two back-to-back control writes. The first sets both bits. The second, one cycle later, clears the display-on bit exactly when the idle state sees the start condition, so both are accepted together. The scoreboard then expects a full power-up whose status-11 step lasts a single cycle. Power-down must follow with zero frame ticks in between.

// File: rtl/lcdps_pkg.sv
package lcdps_pkg;

  typedef enum logic [2:0] {
    S_OFF,
    S_UP_A,
    S_UP_B,
    S_ON,
    S_DN_A,
    S_DN_B
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_ON,
    SRC_OFF_A,
    SRC_OFF_B
  } cnt_src_e;

  typedef struct packed {
    logic     load;
    cnt_src_e src;
    logic     dec;
  } cnt_strobe_t;

endpackage

// File: rtl/lcdps_dp.sv
module lcdps_dp
  import lcdps_pkg::*;
#(
  parameter int DLY_W     = 4,
  parameter int ON_DLY_M1 = 1,
  parameter int OFF_A_RST = 0,
  parameter int OFF_B_RST = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dlyWr,
  input  logic [DLY_W-1:0] dlyAIn,
  input  logic [DLY_W-1:0] dlyBIn,
  input  cnt_strobe_t      strobe,
  output logic [DLY_W-1:0] dlyA,
  output logic [DLY_W-1:0] dlyB,
  output logic             cntZero
);

  localparam logic [DLY_W-1:0] ON_VAL   = DLY_W'(ON_DLY_M1);
  localparam logic [DLY_W-1:0] A_RESET  = DLY_W'(OFF_A_RST);
  localparam logic [DLY_W-1:0] B_RESET  = DLY_W'(OFF_B_RST);

  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] loadVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyA <= A_RESET;
      dlyB <= B_RESET;
    end else if (dlyWr) begin
      dlyA <= dlyAIn;
      dlyB <= dlyBIn;
    end
  end

  always_comb begin
    unique case (strobe.src)
      SRC_OFF_A: loadVal = dlyA;
      SRC_OFF_B: loadVal = dlyB;
      default:   loadVal = ON_VAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.load) begin
      cnt <= loadVal;
    end else if (strobe.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // R5/R6: the frame counter must never wrap below zero
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> (cnt != '0));

  // R7: the counter moves only when control asks for it
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.dec) |=> $stable(cnt));

endmodule

// File: rtl/lcdps_ctrl.sv
module lcdps_ctrl
  import lcdps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameTick,
  input  logic        ctrlWr,
  input  logic        ctrlOnIn,
  input  logic        ctrlConfIn,
  input  logic        cntZero,
  output cnt_strobe_t strobe,
  output logic        onBit,
  output logic        confBit,
  output logic        logicEn,
  output logic        dispEn,
  output logic        biasEn,
  output logic [1:0]  pwrState
);

  seq_state_e state, nxtState;
  logic busy;
  logic phaseDone;

  assign busy      = (state != S_OFF) && (state != S_ON);
  assign phaseDone = frameTick && cntZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onBit   <= 1'b0;
      confBit <= 1'b0;
    end else if (ctrlWr) begin
      confBit <= ctrlConfIn;
      if (!busy) onBit <= ctrlOnIn;
    end
  end

  always_comb begin
    nxtState = state;
    strobe   = '{load: 1'b0, src: SRC_ON, dec: 1'b0};
    unique case (state)
      S_OFF: if (onBit && confBit) begin
        nxtState    = S_UP_A;
        strobe.load = 1'b1;
        strobe.src  = SRC_ON;
      end
      S_UP_A: if (phaseDone) begin
        nxtState    = S_UP_B;
        strobe.load = 1'b1;
        strobe.src  = SRC_ON;
      end else if (frameTick) begin
        strobe.dec = 1'b1;
      end
      S_UP_B: if (phaseDone) begin
        nxtState = S_ON;
      end else if (frameTick) begin
        strobe.dec = 1'b1;
      end
      S_ON: if (!onBit) begin
        nxtState    = S_DN_A;
        strobe.load = 1'b1;
        strobe.src  = SRC_OFF_A;
      end
      S_DN_A: if (phaseDone) begin
        nxtState    = S_DN_B;
        strobe.load = 1'b1;
        strobe.src  = SRC_OFF_B;
      end else if (frameTick) begin
        strobe.dec = 1'b1;
      end
      S_DN_B: if (phaseDone) begin
        nxtState = S_OFF;
      end else if (frameTick) begin
        strobe.dec = 1'b1;
      end
      default: nxtState = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_OFF;
    else       state <= nxtState;
  end

  always_comb begin
    logicEn  = 1'b0;
    dispEn   = 1'b0;
    biasEn   = 1'b0;
    pwrState = 2'b00;
    unique case (state)
      S_UP_A, S_DN_B: begin
        logicEn  = 1'b1;
        pwrState = 2'b01;
      end
      S_UP_B, S_DN_A: begin
        logicEn  = 1'b1;
        dispEn   = 1'b1;
        pwrState = 2'b10;
      end
      S_ON: begin
        logicEn  = 1'b1;
        dispEn   = 1'b1;
        biasEn   = 1'b1;
        pwrState = 2'b11;
      end
      default: ;
    endcase
  end

  // R3: bias only with display and logic, display only with logic
  assert_bias_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    biasEn |-> (dispEn && logicEn));
  assert_disp_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    dispEn |-> logicEn);

  // R3: status moves one step at a time
  assert_status_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(pwrState) ||
              ({1'b0, pwrState} == {1'b0, $past(pwrState)} + 3'd1) ||
              ({1'b0, pwrState} + 3'd1 == {1'b0, $past(pwrState)})));

  // R7: no progress through a timed phase without a frame tick
  assert_tick_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameTick) |=> $stable(pwrState));

  // R8: display-on bit frozen while sequencing
  assert_on_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(onBit));

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcdps_pkg::*;
#(
  parameter int DLY_W     = 4,
  parameter int ON_DLY_M1 = 1,
  parameter int OFF_A_RST = 0,
  parameter int OFF_B_RST = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameTick,
  input  logic             ctrlWr,
  input  logic             ctrlOnIn,
  input  logic             ctrlConfIn,
  input  logic             dlyWr,
  input  logic [DLY_W-1:0] dlyAIn,
  input  logic [DLY_W-1:0] dlyBIn,
  output logic             logicEn,
  output logic             dispEn,
  output logic             biasEn,
  output logic [1:0]       pwrState,
  output logic             onBit,
  output logic             confBit,
  output logic [DLY_W-1:0] dlyA,
  output logic [DLY_W-1:0] dlyB
);

  cnt_strobe_t strobe;
  logic        cntZero;

  lcdps_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameTick  (frameTick),
    .ctrlWr     (ctrlWr),
    .ctrlOnIn   (ctrlOnIn),
    .ctrlConfIn (ctrlConfIn),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .onBit      (onBit),
    .confBit    (confBit),
    .logicEn    (logicEn),
    .dispEn     (dispEn),
    .biasEn     (biasEn),
    .pwrState   (pwrState)
  );

  lcdps_dp #(
    .DLY_W     (DLY_W),
    .ON_DLY_M1 (ON_DLY_M1),
    .OFF_A_RST (OFF_A_RST),
    .OFF_B_RST (OFF_B_RST)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dlyWr   (dlyWr),
    .dlyAIn  (dlyAIn),
    .dlyBIn  (dlyBIn),
    .strobe  (strobe),
    .dlyA    (dlyA),
    .dlyB    (dlyB),
    .cntZero (cntZero)
  );

endmodule

// File: tb/lcd_pwr_seq_bench.sv
module lcd_pwr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DLY_W      = 4;
  localparam int ON_DLY_M1  = 1;
  localparam int ON_TICKS   = ON_DLY_M1 + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             frameTick = 1'b0;
  logic             ctrlWr = 1'b0;
  logic             ctrlOnIn = 1'b0;
  logic             ctrlConfIn = 1'b0;
  logic             dlyWr = 1'b0;
  logic [DLY_W-1:0] dlyAIn = '0;
  logic [DLY_W-1:0] dlyBIn = '0;
  logic             logicEn, dispEn, biasEn, onBit, confBit;
  logic [1:0]       pwrState;
  logic [DLY_W-1:0] dlyA, dlyB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [4:0] outs;
    int         ticks;
    string      req;
  } exp_item_t;

  exp_item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_pwr_seq #(.DLY_W(DLY_W), .ON_DLY_M1(ON_DLY_M1)) u_lcd_pwr_seq (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .ctrlWr(ctrlWr), .ctrlOnIn(ctrlOnIn), .ctrlConfIn(ctrlConfIn),
    .dlyWr(dlyWr), .dlyAIn(dlyAIn), .dlyBIn(dlyBIn),
    .logicEn(logicEn), .dispEn(dispEn), .biasEn(biasEn), .pwrState(pwrState),
    .onBit(onBit), .confBit(confBit), .dlyA(dlyA), .dlyB(dlyB)
  );

  task automatic checkVal(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectStep(logic [4:0] outs, int ticks, string req);
    exp_item_t it;
    it.outs = outs; it.ticks = ticks; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: on every output change, pop and compare outputs and frame count
  logic [4:0] prevOuts = '0;
  int         tickCnt = 0;
  always @(negedge clk) begin
    logic [4:0] cur;
    exp_item_t  it;
    if (rstN) begin
      cur = {logicEn, dispEn, biasEn, pwrState};
      if (cur != prevOuts) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected change: actual %b expected none", cur);
        end else begin
          it = expQ.pop_front();
          if (cur != it.outs || tickCnt != it.ticks) begin
            errors++;
            $display("FAIL %s: actual outs %b ticks %0d expected outs %b ticks %0d",
                     it.req, cur, tickCnt, it.outs, it.ticks);
          end
        end
        tickCnt = 0;
      end
      prevOuts = cur;
      if (frameTick) tickCnt++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic writeCtrl(logic onV, logic confV);
    @(posedge clk); #1;
    ctrlWr = 1'b1; ctrlOnIn = onV; ctrlConfIn = confV;
    @(posedge clk); #1;
    ctrlWr = 1'b0;
  endtask

  task automatic writeCtrlPair(logic on1, logic on2);
    @(posedge clk); #1;
    ctrlWr = 1'b1; ctrlOnIn = on1; ctrlConfIn = 1'b1;
    @(posedge clk); #1;
    ctrlOnIn = on2;
    @(posedge clk); #1;
    ctrlWr = 1'b0;
  endtask

  task automatic writeDly(int a, int b);
    @(posedge clk); #1;
    dlyWr = 1'b1; dlyAIn = DLY_W'(a); dlyBIn = DLY_W'(b);
    @(posedge clk); #1;
    dlyWr = 1'b0;
  endtask

  task automatic sendTicks(int n);
    repeat (n) begin
      @(posedge clk); #1; frameTick = 1'b1;
      @(posedge clk); #1; frameTick = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic expectUp();
    expectStep(5'b100_01, 0, "R3");
    expectStep(5'b110_10, ON_TICKS, "R3");
    expectStep(5'b111_11, ON_TICKS, "R3");
  endtask

  task automatic fullCycle(int a, int b, bit probe);
    writeDly(a, b);
    expectUp();
    writeCtrl(1'b1, 1'b1);
    if (probe) begin
      idle(20);
      #1 checkVal("R7 no advance without tick", pwrState, 1);
      writeCtrl(1'b0, 1'b1);
      #1 checkVal("R8 on bit held during power-up", onBit, 1);
    end
    sendTicks(ON_TICKS);
    sendTicks(ON_TICKS);
    idle(3);
    expectStep(5'b110_10, 0, "R4");
    expectStep(5'b100_01, a + 1, "R5");
    expectStep(5'b000_00, b + 1, "R6");
    writeCtrl(1'b0, 1'b1);
    if (probe) begin
      writeCtrl(1'b1, 1'b1);
      #1 checkVal("R8 on bit held during power-down", onBit, 0);
    end
    sendTicks(a + 1);
    sendTicks(b + 1);
    idle(4);
    checkVal("R5/R6 sequence fully consumed", expQ.size(), 0);
  endtask

  initial begin
    idle(3);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 logicEn", logicEn, 0);
    checkVal("R1 dispEn", dispEn, 0);
    checkVal("R1 biasEn", biasEn, 0);
    checkVal("R1 pwrState", pwrState, 0);
    checkVal("R1 onBit/confBit", {onBit, confBit}, 0);
    checkVal("R1 dlyA", dlyA, 0);
    checkVal("R1 dlyB", dlyB, 15);

    writeCtrl(1'b1, 1'b0);
    idle(8);
    #1 checkVal("R2 no start without confirm", pwrState, 0);

    fullCycle(0, 15, 1'b1);
    fullCycle(1, 1, 1'b0);
    fullCycle(15, 0, 1'b0);

    // R9: clear write lands on the same edge as the start decision
    writeDly(1, 0);
    expectUp();
    expectStep(5'b110_10, 0, "R9");
    expectStep(5'b100_01, 2, "R5");
    expectStep(5'b000_00, 1, "R6");
    writeCtrlPair(1'b1, 1'b0);
    #1 checkVal("R9 on bit cleared at start", onBit, 0);
    sendTicks(ON_TICKS);
    sendTicks(ON_TICKS);
    idle(3);
    sendTicks(2);
    sendTicks(1);
    idle(4);
    checkVal("R9 sequence fully consumed", expQ.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule